// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block supports one core's atomic read-modify-write sequences. These sequences are built from two operations. The first is a load that also reserves the word it read. The second is a store that is only allowed if that word is still untouched. The monitor keeps a single reservation: an aligned word address and a valid flag. The flag is set when a load-linked completes. It is cleared by anything that could have changed the word, or that ends the atomic sequence.

The monitor watches two streams of ordinary writes. One stream is the local core's own stores. The other is snooped writes from other agents on the bus. It also watches an exception/interrupt event. When a store-conditional is presented, the monitor answers in the same cycle with two outputs. The first is a permit that gates the memory write. The second is the status word that the core writes back to the destination register: 1 on success, 0 on failure.

Top module: `resv_monitor`

## Requirements
- R1: A load-linked with no conflicting event in the same cycle records the word address (addr[ADDR_W-1:2]) and marks the reservation valid; a store-conditional to that word in a later cycle, with nothing in between, succeeds.
- R2: A successful store-conditional raises scAllow and drives scResult to the value 1, combinationally in the cycle where scValid is high.
- R3: A failing store-conditional, and any cycle without one, drives scAllow low and scResult to 0; bits [DATA_W-1:1] of scResult are always 0.
- R4: After reset, or after a reset that comes between the load-linked and the store-conditional, no reservation exists and a store-conditional fails.
- R5: A local write or a bus write whose word address equals the reserved word clears the reservation.
- R6: A write to a different word, including the neighbouring word, leaves the reservation valid.
- R7: Every store-conditional clears the reservation, whether it passes or fails, so a second store-conditional fails.
- R8: A store-conditional to a word other than the reserved one fails.
- R9: A pulse on flushEvt (exception or interrupt) clears the reservation.
- R10: Address bits [1:0] are ignored in every comparison, for store-conditional addresses and for write addresses alike.
- R11: A matching write or a flush in the same cycle as a store-conditional is ordered first, so that store-conditional fails.
- R12: A load-linked replaces any earlier reservation. If a write to the load-linked word, a flush or a store-conditional occurs in the same cycle, no reservation is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| llValid | input | 1 | A load-linked completes this cycle |
| llAddr | input | ADDR_W | Byte address of the load-linked |
| scValid | input | 1 | A store-conditional requests permission this cycle |
| scAddr | input | ADDR_W | Byte address of the store-conditional |
| localWrValid | input | 1 | The local core performs an ordinary store |
| localWrAddr | input | ADDR_W | Byte address of the local store |
| busWrValid | input | 1 | Another agent writes memory (snooped) |
| busWrAddr | input | ADDR_W | Byte address of the snooped write |
| flushEvt | input | 1 | Exception or interrupt taken; drops the reservation |
| scAllow | output | 1 | The store-conditional may write memory |
| scResult | output | DATA_W | Status word for the destination register (1 pass, 0 fail) |

## Verification
The bench targets same-cycle orderings. In one case a snooped write lands on the reserved word in the very cycle of the store-conditional; a monitor that samples only the registered flag would let the store through. In another a load-linked coincides with a write or a flush; a design that lets the set win would hand out a reservation that is already stale.

It also probes the address compare. A write to the same word with different low bits must kill the reservation. A write to the adjacent word must not; a compare that is one bit too wide or too narrow shows up as a pass where a fail is expected, or the reverse.

Other checks cover a failed store-conditional that leaves the reservation alive, a reset between the two operations, and a second load-linked that moves the reservation elsewhere. Each of these shows up as a second store-conditional that wrongly succeeds.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Byte-offset bits dropped from every address compare (word granularity).
  localparam int WORD_LSB = 2;

  // Strobes from the control decision to the reservation datapath.
  typedef struct packed {
    logic setResv;    // capture llAddr word, mark valid
    logic clearResv;  // drop the reservation
    logic grant;      // store-conditional may proceed
  } resv_strobe_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  resv_strobe_t      strb,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [ADDR_W-1:0] localWrAddr,
  input  logic [ADDR_W-1:0] busWrAddr,
  output logic              resvValid,
  output logic              scHit,
  output logic              localHit,
  output logic              busHit,
  output logic              llLocalHit,
  output logic              llBusHit,
  output logic [DATA_W-1:0] scResult
);

  localparam int WORD_W = ADDR_W - WORD_LSB;
  localparam int NPROBE = 3;  // sc, local write, bus write
  localparam int NWRPROBE = 2;

  logic [WORD_W-1:0] resvWord;
  logic [WORD_W-1:0] llWord;
  logic [WORD_W-1:0] probeWord [NPROBE];
  logic [NPROBE-1:0] probeHit;
  logic [NWRPROBE-1:0] llProbeHit;

  assign llWord       = llAddr[ADDR_W-1:WORD_LSB];
  assign probeWord[0] = scAddr[ADDR_W-1:WORD_LSB];
  assign probeWord[1] = localWrAddr[ADDR_W-1:WORD_LSB];
  assign probeWord[2] = busWrAddr[ADDR_W-1:WORD_LSB];

  // Compare each observed address against the stored reservation.
  for (genvar p = 0; p < NPROBE; p++) begin : g_resvCmp
    assign probeHit[p] = (probeWord[p] == resvWord);
  end

  // Compare write addresses against an incoming load-linked word.
  for (genvar w = 0; w < NWRPROBE; w++) begin : g_llCmp
    assign llProbeHit[w] = (probeWord[w+1] == llWord);
  end

  assign scHit      = probeHit[0];
  assign localHit   = probeHit[1];
  assign busHit     = probeHit[2];
  assign llLocalHit = llProbeHit[0];
  assign llBusHit   = llProbeHit[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvWord  <= '0;
    end else if (strb.setResv) begin
      resvValid <= 1'b1;
      resvWord  <= llWord;
    end else if (strb.clearResv) begin
      resvValid <= 1'b0;
    end
  end

  assign scResult = {{(DATA_W-1){1'b0}}, strb.grant};

  // R1: a set strobe leaves a valid reservation holding the load-linked word
  a_r1_ll_records: assert property (@(posedge clk) disable iff (!rstN)
    strb.setResv |=> (resvValid && resvWord == $past(llWord)));

  // R2: permission is only ever granted against a live reservation
  a_r2_grant_has_resv: assert property (@(posedge clk) disable iff (!rstN)
    strb.grant |-> resvValid);

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         llValid,
  input  logic         scValid,
  input  logic         localWrValid,
  input  logic         busWrValid,
  input  logic         flushEvt,
  input  logic         resvValid,
  input  logic         scHit,
  input  logic         localHit,
  input  logic         busHit,
  input  logic         llLocalHit,
  input  logic         llBusHit,
  output resv_strobe_t strb
);

  logic resvTouched;  // the stored word is disturbed this cycle
  logic llSpoiled;    // the incoming load-linked word is disturbed this cycle

  always_comb begin
    resvTouched = (localWrValid && localHit) || (busWrValid && busHit) || flushEvt;
    llSpoiled   = (localWrValid && llLocalHit) || (busWrValid && llBusHit)
                  || flushEvt || scValid;

    strb           = '0;
    strb.grant     = scValid && resvValid && scHit && !resvTouched;
    strb.setResv   = llValid && !llSpoiled;
    strb.clearResv = scValid || resvTouched;
  end

  // R7: any store-conditional consumes the reservation
  a_r7_sc_consumes: assert property (@(posedge clk) disable iff (!rstN)
    scValid |=> !resvValid);

  // R9: an exception or interrupt drops the reservation
  a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rstN)
    flushEvt |=> !resvValid);

  // R5: a snooped write to the reserved word kills it unless a new load-linked replaces it
  a_r5_snoop_kills: assert property (@(posedge clk) disable iff (!rstN)
    (busWrValid && busHit && !llValid) |=> !resvValid);

  // R11: a same-cycle flush forbids the store
  a_r11_flush_blocks: assert property (@(posedge clk) disable iff (!rstN)
    flushEvt |-> !strb.grant);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              localWrValid,
  input  logic [ADDR_W-1:0] localWrAddr,
  input  logic              busWrValid,
  input  logic [ADDR_W-1:0] busWrAddr,
  input  logic              flushEvt,
  output logic              scAllow,
  output logic [DATA_W-1:0] scResult
);

  resv_strobe_t strb;
  logic resvValid, scHit, localHit, busHit, llLocalHit, llBusHit;

  resv_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .llValid      (llValid),
    .scValid      (scValid),
    .localWrValid (localWrValid),
    .busWrValid   (busWrValid),
    .flushEvt     (flushEvt),
    .resvValid    (resvValid),
    .scHit        (scHit),
    .localHit     (localHit),
    .busHit       (busHit),
    .llLocalHit   (llLocalHit),
    .llBusHit     (llBusHit),
    .strb         (strb)
  );

  resv_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .llAddr      (llAddr),
    .scAddr      (scAddr),
    .localWrAddr (localWrAddr),
    .busWrAddr   (busWrAddr),
    .resvValid   (resvValid),
    .scHit       (scHit),
    .localHit    (localHit),
    .busHit      (busHit),
    .llLocalHit  (llLocalHit),
    .llBusHit    (llBusHit),
    .scResult    (scResult)
  );

  assign scAllow = strb.grant;

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // ops bits: {ll, sc, localWr, busWr, flush}; ll/sc use addrA, writes use addrB
  typedef struct packed {
    logic [4:0]  ops;
    logic [31:0] addrA;
    logic [31:0] addrB;
    logic        expPass;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 34;
  localparam vec_t VECS [NVEC] = '{
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd4},   // R4 no reservation yet
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},   // R1 ll A
    '{5'b01000, 32'h100, 32'h0,   1'b1, 8'd2},   // R2 sc A passes
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd7},   // R7 second sc fails
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b00010, 32'h0,   32'h200, 1'b0, 8'd6},   // R6 bus write other word
    '{5'b00100, 32'h0,   32'h104, 1'b0, 8'd6},   // R6 local write neighbour word
    '{5'b01000, 32'h102, 32'h0,   1'b1, 8'd10},  // R10 sc low bits differ
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b00100, 32'h0,   32'h100, 1'b0, 8'd5},   // R5 local write kills
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd5},
    '{5'b10000, 32'h101, 32'h0,   1'b0, 8'd1},
    '{5'b00010, 32'h0,   32'h103, 1'b0, 8'd10},  // R10 bus write low bits differ
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd5},   // R5 bus kill observed
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b01000, 32'h200, 32'h0,   1'b0, 8'd8},   // R8 wrong word
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd7},   // R7 failed sc consumed it
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b00001, 32'h0,   32'h0,   1'b0, 8'd9},   // R9 flush
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd9},
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b01010, 32'h100, 32'h100, 1'b0, 8'd11},  // R11 sc with same-cycle bus hit
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd11},
    '{5'b10000, 32'h100, 32'h0,   1'b0, 8'd1},
    '{5'b10000, 32'h200, 32'h0,   1'b0, 8'd12},  // R12 ll B replaces A
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd12},
    '{5'b10000, 32'h200, 32'h0,   1'b0, 8'd12},
    '{5'b01000, 32'h200, 32'h0,   1'b1, 8'd12},
    '{5'b10010, 32'h100, 32'h100, 1'b0, 8'd12},  // R12 ll with same-word bus write
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd12},
    '{5'b10001, 32'h100, 32'h0,   1'b0, 8'd12},  // R12 ll with flush
    '{5'b01000, 32'h100, 32'h0,   1'b0, 8'd12},
    '{5'b10010, 32'h100, 32'h200, 1'b0, 8'd6},   // R6 ll with unrelated bus write
    '{5'b01000, 32'h100, 32'h0,   1'b1, 8'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic llValid = 1'b0, scValid = 1'b0, localWrValid = 1'b0, busWrValid = 1'b0, flushEvt = 1'b0;
  logic [ADDR_W-1:0] llAddr = '0, scAddr = '0, localWrAddr = '0, busWrAddr = '0;
  logic scAllow;
  logic [DATA_W-1:0] scResult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .llValid(llValid), .llAddr(llAddr),
    .scValid(scValid), .scAddr(scAddr),
    .localWrValid(localWrValid), .localWrAddr(localWrAddr),
    .busWrValid(busWrValid), .busWrAddr(busWrAddr),
    .flushEvt(flushEvt),
    .scAllow(scAllow), .scResult(scResult)
  );

  task automatic drive(input logic [4:0] ops, input logic [31:0] a, input logic [31:0] b);
    {llValid, scValid, localWrValid, busWrValid, flushEvt} = ops;
    llAddr = a; scAddr = a; localWrAddr = b; busWrAddr = b;
  endtask

  // Compare both outputs against the expected pass/fail outcome.
  task automatic expect_out(input logic pass, input string tag);
    logic [DATA_W-1:0] expRes;
    expRes = {{(DATA_W-1){1'b0}}, pass};
    checks++;
    if (scAllow !== pass || scResult !== expRes) begin
      errors++;
      $display("FAIL %s: scAllow=%0b scResult=%0h expected scAllow=%0b scResult=%0h",
               tag, scAllow, scResult, pass, expRes);
    end
  endtask

  // Drive one cycle at the falling edge, check the combinational answer, let the edge pass.
  task automatic step(input logic [4:0] ops, input logic [31:0] a, input logic [31:0] b,
                      input logic pass, input string tag);
    @(negedge clk);
    drive(ops, a, b);
    #1;
    expect_out(pass, tag);
  endtask

  initial begin
    drive(5'b0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    expect_out(1'b0, "R3 reset idle");
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ops, VECS[i].addrA, VECS[i].addrB, VECS[i].expPass,
           $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R3: idle cycle with a live reservation still reports zero
    step(5'b10000, 32'h300, 32'h0, 1'b0, "R1 ll before idle");
    step(5'b00000, 32'h300, 32'h0, 1'b0, "R3 idle no sc");
    step(5'b01000, 32'h300, 32'h0, 1'b1, "R3 reservation survived idle");

    // R4: reset between load-linked and store-conditional
    step(5'b10000, 32'h400, 32'h0, 1'b0, "R1 ll before reset");
    @(negedge clk);
    drive(5'b0, 32'h0, 32'h0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    step(5'b01000, 32'h400, 32'h0, 1'b0, "R4 reset drops reservation");

    // R11: local write in the sc cycle, and flush in the sc cycle
    step(5'b10000, 32'h500, 32'h0, 1'b0, "R1 ll");
    step(5'b01100, 32'h500, 32'h502, 1'b0, "R11 sc with local write");
    step(5'b10000, 32'h500, 32'h0, 1'b0, "R1 ll");
    step(5'b01001, 32'h500, 32'h0, 1'b0, "R11 sc with flush");

    // R12: sc and ll in one cycle sets nothing
    step(5'b11000, 32'h600, 32'h0, 1'b0, "R12 ll with sc");
    step(5'b01000, 32'h600, 32'h0, 1'b0, "R12 no reservation after ll+sc");

    @(negedge clk);
    drive(5'b0, 32'h0, 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule